// File: doc/BRIEF.md
# Processor Status Register with ALU Flag Logic

This block holds the 8-bit status word of a small accumulator-style processor and produces the ALU result with its flags. Each cycle in which `op_valid` is high, the ALU works on two operands under a 4-bit opcode and drives `alu_out`. The flags that the operation defines are loaded into the status word. When the decoded destination of the operation is the status word itself (`dst_is_stat`), the ALU result is the data written into it. That write is screened: any flag-producing operation keeps its flag-logic values in bits 2:0, and bits 4:3 never take software data.

Two status bits record power and watchdog history. They react only to a watchdog-clear strobe, a sleep-entry strobe and a watchdog-timeout strobe. The asynchronous active-low reset stands for power-on reset and overrides everything else. Bits 5 and 7 are brought out as the bank bits for direct and indirect data addressing.

Top module: `cpu_status_unit`

## Requirements
- R1: While reset is low, and after its release until the first operation or event, `stat_q` is 8'h18: bits 7:5 and 2:0 are 0, and bits 4 (timeout flag) and 3 (power-down flag) are 1.
- R2: `dir_bank` always equals `stat_q[5]` and `ind_bank` always equals `stat_q[7]`. Bit 6 is a plain writable bit. Bit 2 is zero flag Z, bit 1 is nibble carry DC, bit 0 is carry C.
- R3: Add (opcode 0) gives `alu_out` = (a+b) mod 256, C = carry out of bit 7, DC = carry out of bit 3, and Z = (result==0).
- R4: Subtract (opcode 1) gives `alu_out` = (a-b) mod 256, computed as a + ~b + 1. C = 1 when a >= b. DC = 1 when a[3:0] >= b[3:0]. Z = (result==0).
- R5: AND (2), OR (3), XOR (4) and clear (7, result 0) set Z to (result==0) and leave DC and C unchanged.
- R6: Rotate left through carry (5) gives {a[6:0], C} with new C = a[7]. Rotate right through carry (6) gives {C, a[7:1]} with new C = a[0]. Z and DC are unchanged.
- R7: An operation that updates any of Z/DC/C and targets the status word writes `alu_out[7:5]` into bits 7:5. It discards `alu_out[2:0]`, so bits 2:0 keep the flag logic's values (or the old value for a flag the operation does not define).
- R8: Clear aimed at the status word gives 000u_u1uu: bits 7:5 = 0, Z = 1, bits 4:3 and 1:0 unchanged.
- R9: Move (8, result a), nibble swap (9, {a[3:0],a[7:4]}), bit set (10, a with bit b[2:0] set) and bit clear (11, a with bit b[2:0] cleared) change no flag. Aimed at the status word, they write `alu_out[7:5]` and `alu_out[2:0]` directly.
- R10: No write to the status word changes bits 4:3.
- R11: Watchdog timeout clears bit 4. Otherwise, watchdog-clear or sleep entry sets bit 4.
- R12: Sleep entry clears bit 3. Otherwise, watchdog-clear sets bit 3. Timeout and sleep together give bit 4 = 0 and bit 3 = 0.
- R13: With `op_valid` low and no event strobe, `stat_q` holds its value whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| op_valid | input | 1 | An operation executes this cycle |
| op_code | input | 4 | Operation select (codes in R3–R9) |
| opnd_a | input | 8 | First operand / source of rotate, move, swap and bit operations |
| opnd_b | input | 8 | Second operand; bits 2:0 give the bit index for bit set/clear |
| dst_is_stat | input | 1 | Result is written into the status word |
| wdt_clear | input | 1 | Watchdog-clear event strobe |
| sleep_enter | input | 1 | Sleep-entry event strobe |
| wdt_timeout | input | 1 | Watchdog-timeout event strobe |
| alu_out | output | 8 | ALU result |
| stat_q | output | 8 | Status register value |
| dir_bank | output | 1 | Bank bit for direct addressing |
| ind_bank | output | 1 | Bank bit for indirect addressing |

## Verification
Directed operand pairs place the adder at its edges. A nibble overflow without a byte carry separates DC from C, 0xFF+0x01 gives a zero result with carry, and equal, smaller and larger subtrahends show the inverted-borrow sense of both carries. Writes of all-ones and all-zeros into the status word, one for each operation class, separate the guarded bits 2:0 from the always-written bits 7:5 and show that bits 4:3 ignore data. Event strobes, alone, paired with each other and paired with writes, check the event priorities. A long run of pseudo-random operations, destinations and strobes, including idle cycles with live inputs, is compared cycle by cycle against a behavioural model.

// File: rtl/cpu_stat_pkg.sv
package cpu_stat_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_RLC  = 4'd5,
    OP_RRC  = 4'd6,
    OP_CLR  = 4'd7,
    OP_MOV  = 4'd8,
    OP_SWAP = 4'd9,
    OP_BSET = 4'd10,
    OP_BCLR = 4'd11
  } op_e;

  localparam int STAT_W = 8;
  // positions fixed by the consumers of the status word
  localparam int B_IND = 7;
  localparam int B_DIR = 5;
  localparam int B_TO  = 4;
  localparam int B_PD  = 3;
  localparam int B_Z   = 2;
  localparam int B_DC  = 1;
  localparam int B_C   = 0;

  localparam logic [STAT_W-1:0] STAT_RST = 8'h18;

  typedef struct packed {
    logic z;
    logic dc;
    logic c;
    logic upd_z;
    logic upd_dc;
    logic upd_c;
  } flag_t;

endpackage

// File: rtl/stat_rst_sync.sv
module stat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/stat_alu.sv
module stat_alu
  import cpu_stat_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  output logic [W-1:0] res,
  output flag_t        flg
);

  localparam int NIB  = W / 2;
  localparam int IDXW = $clog2(W);

  logic         is_sub;
  logic [W-1:0] b_eff;
  logic [W:0]   sum_full;
  logic [NIB:0] sum_low;
  logic [W-1:0] bit_mask;

  assign is_sub   = (op == OP_SUB);
  assign b_eff    = is_sub ? ~b : b;
  assign sum_full = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
  assign sum_low  = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, is_sub};
  assign bit_mask = {{(W-1){1'b0}}, 1'b1} << b[IDXW-1:0];

  always_comb begin
    res        = a;
    flg        = '0;
    flg.c      = c_in;
    unique case (op)
      OP_ADD, OP_SUB: begin
        res        = sum_full[W-1:0];
        flg.c      = sum_full[W];
        flg.dc     = sum_low[NIB];
        flg.upd_c  = 1'b1;
        flg.upd_dc = 1'b1;
        flg.upd_z  = 1'b1;
      end
      OP_AND: begin res = a & b; flg.upd_z = 1'b1; end
      OP_OR:  begin res = a | b; flg.upd_z = 1'b1; end
      OP_XOR: begin res = a ^ b; flg.upd_z = 1'b1; end
      OP_CLR: begin res = '0;    flg.upd_z = 1'b1; end
      OP_RLC: begin
        res       = {a[W-2:0], c_in};
        flg.c     = a[W-1];
        flg.upd_c = 1'b1;
      end
      OP_RRC: begin
        res       = {c_in, a[W-1:1]};
        flg.c     = a[0];
        flg.upd_c = 1'b1;
      end
      OP_SWAP: res = {a[NIB-1:0], a[W-1:NIB]};
      OP_BSET: res = a | bit_mask;
      OP_BCLR: res = a & ~bit_mask;
      default: res = a;
    endcase
    flg.z = (res == '0);
  end

endmodule

// File: rtl/stat_reg_core.sv
module stat_reg_core
  import cpu_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              dst_stat,
  input  logic [2:0]        wr_hi,
  input  logic [2:0]        wr_lo,
  input  flag_t             flg,
  input  logic              wdt_clear,
  input  logic              sleep_enter,
  input  logic              wdt_timeout,
  output logic [STAT_W-1:0] q
);

  logic [STAT_W-1:0] q_d;
  logic              reg_en;
  logic              any_evt;
  logic              sw_wr;
  logic              flags_owned;

  assign any_evt     = wdt_clear | sleep_enter | wdt_timeout;
  assign reg_en      = op_valid | any_evt;
  assign sw_wr       = op_valid & dst_stat;
  assign flags_owned = flg.upd_z | flg.upd_dc | flg.upd_c;

  always_comb begin
    q_d = q;
    if (sw_wr) begin
      q_d[B_IND:B_DIR] = wr_hi;
      if (!flags_owned) q_d[B_Z:B_C] = wr_lo;
    end
    if (op_valid && flg.upd_z)  q_d[B_Z]  = flg.z;
    if (op_valid && flg.upd_dc) q_d[B_DC] = flg.dc;
    if (op_valid && flg.upd_c)  q_d[B_C]  = flg.c;
    if (wdt_timeout)                   q_d[B_TO] = 1'b0;
    else if (wdt_clear || sleep_enter) q_d[B_TO] = 1'b1;
    if (sleep_enter)                   q_d[B_PD] = 1'b0;
    else if (wdt_clear)                q_d[B_PD] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= STAT_RST;
    end else if (reg_en) begin
      q <= q_d;
    end
  end

  // R11: a timeout always leaves the timeout flag low
  p_to_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> !q[B_TO]);

  // R12: sleep entry always leaves the power-down flag low
  p_pd_cleared_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_enter |=> !q[B_PD]);

  // R10: without an event the two history bits never move
  p_hist_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_evt |=> $stable(q[B_TO:B_PD]));

  // R13: idle cycle keeps the whole word
  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid || any_evt) |=> $stable(q));

endmodule

// File: rtl/cpu_status_unit.sv
module cpu_status_unit
  import cpu_stat_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              dst_is_stat,
  input  logic              wdt_clear,
  input  logic              sleep_enter,
  input  logic              wdt_timeout,
  output logic [DATA_W-1:0] alu_out,
  output logic [7:0]        stat_q,
  output logic              dir_bank,
  output logic              ind_bank
);

  logic  rst_core_n;
  op_e   op;
  flag_t flg;

  assign op = op_e'(op_code);

  stat_rst_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  stat_alu #(.W(DATA_W)) u_alu (
    .op   (op),
    .a    (opnd_a),
    .b    (opnd_b),
    .c_in (stat_q[B_C]),
    .res  (alu_out),
    .flg  (flg)
  );

  stat_reg_core u_core (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .op_valid    (op_valid),
    .dst_stat    (dst_is_stat),
    .wr_hi       (alu_out[7:5]),
    .wr_lo       (alu_out[2:0]),
    .flg         (flg),
    .wdt_clear   (wdt_clear),
    .sleep_enter (sleep_enter),
    .wdt_timeout (wdt_timeout),
    .q           (stat_q)
  );

  assign dir_bank = stat_q[B_DIR];
  assign ind_bank = stat_q[B_IND];

  // R8: clear into the status word gives 000u_u1uu
  p_clr_pattern_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op_valid && dst_is_stat && op_code == 4'd7)
      |=> (stat_q[7:5] == 3'b000) && stat_q[B_Z] && (stat_q[1:0] == $past(stat_q[1:0])));

  // R6: rotate left moves the top source bit into carry
  p_rot_left_c_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op_valid && op_code == 4'd5) |=> stat_q[B_C] == $past(opnd_a[DATA_W-1]));

  // R6: rotate right moves the bottom source bit into carry
  p_rot_right_c_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op_valid && op_code == 4'd6) |=> stat_q[B_C] == $past(opnd_a[0]));

endmodule

// File: tb/cpu_status_unit_test.sv
module cpu_status_unit_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid, dst_is_stat, wdt_clear, sleep_enter, wdt_timeout;
  logic [3:0] op_code;
  logic [7:0] opnd_a, opnd_b;
  logic [7:0] alu_out, stat_q;
  logic       dir_bank, ind_bank;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] m_q;
  string      m_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_status_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .dst_is_stat(dst_is_stat),
    .wdt_clear(wdt_clear), .sleep_enter(sleep_enter), .wdt_timeout(wdt_timeout),
    .alu_out(alu_out), .stat_q(stat_q), .dir_bank(dir_bank), .ind_bank(ind_bank)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_state();
    check8(m_tag, stat_q, m_q);
    check8("R2 bank bits", {6'b0, ind_bank, dir_bank}, {6'b0, m_q[7], m_q[5]});
  endtask

  // one cycle: check state, apply inputs, check result, advance model
  task automatic cyc(input logic v, input int op, input int a, input int b,
                     input logic dst, input logic wc, input logic sl, input logic to);
    int res, s;
    logic uz, udc, uc, fz, fdc, fc;
    logic [7:0] n;
    string tag;
    @(negedge clk);
    check_state();
    op_valid = v; op_code = op[3:0]; opnd_a = a[7:0]; opnd_b = b[7:0];
    dst_is_stat = dst; wdt_clear = wc; sleep_enter = sl; wdt_timeout = to;
    #1;
    uz = 0; udc = 0; uc = 0; fdc = 0; fc = 0; res = a;
    case (op)
      0: begin s = a + b; res = s & 255; fc = s > 255;
               fdc = ((a & 15) + (b & 15)) > 15; uz = 1; udc = 1; uc = 1; tag = "R3 add"; end
      1: begin s = a + ((~b) & 255) + 1; res = s & 255; fc = (a >= b);
               fdc = ((a & 15) >= (b & 15)); uz = 1; udc = 1; uc = 1; tag = "R4 sub"; end
      2: begin res = a & b; uz = 1; tag = "R5 and"; end
      3: begin res = a | b; uz = 1; tag = "R5 or"; end
      4: begin res = a ^ b; uz = 1; tag = "R5 xor"; end
      5: begin res = ((a << 1) & 255) | int'(m_q[0]); fc = a[7]; uc = 1; tag = "R6 rotl"; end
      6: begin res = (int'(m_q[0]) << 7) | (a >> 1); fc = a[0]; uc = 1; tag = "R6 rotr"; end
      7: begin res = 0; uz = 1; tag = "R5 clear"; end
      8: begin res = a; tag = "R9 move"; end
      9: begin res = ((a & 15) << 4) | (a >> 4); tag = "R9 swap"; end
      10: begin res = a | (1 << (b & 7)); tag = "R9 bset"; end
      default: begin res = a & ~(1 << (b & 7)) & 255; tag = "R9 bclr"; end
    endcase
    fz = (res == 0);
    check8(tag, alu_out, res[7:0]);
    n = m_q;
    if (v) begin
      if (dst) begin
        n[7:5] = res[7:5];
        if (!(uz || udc || uc)) n[2:0] = res[2:0];
        if (op == 7) tag = "R8 clear to status";
        else if (uz || udc || uc) tag = {"R7 guarded write, ", tag};
        else tag = {"R10 ", tag};
      end
      if (uz) n[2] = fz;
      if (udc) n[1] = fdc;
      if (uc) n[0] = fc;
    end else if (!(wc || sl || to)) begin
      tag = "R13 idle";
    end
    if (to) n[4] = 0; else if (wc || sl) n[4] = 1;
    if (sl) n[3] = 0; else if (wc) n[3] = 1;
    if (wc || sl || to) tag = {tag, " R11 R12 events"};
    m_q = n;
    m_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 8, 8'hA5, 8'h5A, 1, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    rst_n = 0; op_valid = 0; op_code = 0; opnd_a = 0; opnd_b = 0;
    dst_is_stat = 0; wdt_clear = 0; sleep_enter = 0; wdt_timeout = 0;
    m_q = 8'h18; m_tag = "R1 reset";
    #(CLK_PERIOD * 3 + 2);
    check8("R1 reset value", stat_q, 8'h18);
    @(negedge clk); rst_n = 1;
    idle(4);
    // R3 nibble carry only, then zero with carry
    cyc(1, 0, 8'h0F, 8'h01, 0, 0, 0, 0);
    cyc(1, 0, 8'hFF, 8'h01, 0, 0, 0, 0);
    // R4 equal, borrow, no borrow
    cyc(1, 1, 8'h05, 8'h05, 0, 0, 0, 0);
    cyc(1, 1, 8'h03, 8'h05, 0, 0, 0, 0);
    cyc(1, 1, 8'h30, 8'h01, 0, 0, 0, 0);
    // R9 and R10: move all-ones into status, then all-zeros
    cyc(1, 8, 8'hFF, 0, 1, 0, 0, 0);
    cyc(1, 8, 8'h00, 0, 1, 0, 0, 0);
    cyc(1, 8, 8'hFF, 0, 1, 0, 0, 0);
    // R8 clear into status
    cyc(1, 7, 8'h55, 8'h55, 1, 0, 0, 0);
    @(negedge clk);
    check8("R8 pattern 000u_u1uu", stat_q, 8'h1F);
    // R7 add with all-ones result into status: bits 2:0 from flags
    cyc(1, 0, 8'hFE, 8'h01, 1, 0, 0, 0);
    // R6 rotates
    cyc(1, 5, 8'h80, 0, 0, 0, 0, 0);
    cyc(1, 6, 8'h01, 0, 0, 0, 0, 0);
    // R9 bit ops on bank bits
    cyc(1, 10, 8'h00, 8'h07, 1, 0, 0, 0);
    cyc(1, 11, 8'hFF, 8'h05, 1, 0, 0, 0);
    cyc(1, 9, 8'h5A, 0, 1, 0, 0, 0);
    // R11 R12 events
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 1, 1, 0);
    cyc(1, 8, 8'h18, 0, 1, 1, 0, 0);
    idle(2);
    // pseudo-random run
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom;
      cyc((r & 3) != 0, $urandom_range(0, 11), $urandom_range(0, 255),
          $urandom_range(0, 255), r[2], r[7:4] == 0, r[11:8] == 0, r[15:12] == 0);
    end
    // mid-run reset
    @(negedge clk);
    check_state();
    rst_n = 0;
    #1;
    check8("R1 async reset", stat_q, 8'h18);
    m_q = 8'h18; m_tag = "R1 after reset";
    @(negedge clk); rst_n = 1;
    idle(4);
    cyc(1, 1, 8'h00, 8'h01, 1, 0, 0, 0);
    idle(1);
    finish_run();
  end

endmodule